// File: doc/BRIEF.md
# Immediate-Operand Data-Processing Execute Unit

This block is the execute stage for 32-bit data-processing instructions whose second operand is an immediate that an earlier stage has already expanded to full width. Each clock cycle it takes a 4-bit operation code, a set-flags bit, the destination and first-source register indices, the first-source register value, the expanded immediate, the current carry and overflow flags, and the carry-out produced by the immediate expander. One clock edge later it presents the result, a register write enable with the destination index, and new N/Z/C/V flags with a flag write enable.

The decode is irregular. When the destination index is the all-ones index and set-flags is 1, AND, XOR, ADD and SUB become test or compare forms. These update the flags and write no register. When the first-source index is the all-ones index, OR and OR-NOT become move and move-negated forms of the immediate. Operation codes outside the implemented set raise an illegal output and suppress every write.

All arithmetic forms share one adder. In front of it, a swap, an inversion and a carry-in choice select the operands. Logical forms share one bitwise unit.

Top module: `imm_dp_exec`

## Requirements
- R1: A synchronous active-high reset clears every output to zero on the next clock edge, including result, indices, enables, flags and illegal.
- R2: The result appears one clock edge after the inputs. The logical codes give: 0 = Rn AND imm, 1 = Rn AND NOT imm, 2 = Rn OR imm, 3 = Rn OR NOT imm, 4 = Rn XOR imm.
- R3: With first-source index 15, code 2 yields imm and code 3 yields NOT imm, whatever value Rn holds.
- R4: The arithmetic codes give: 8 = Rn + imm, 0xA = Rn + imm + C, 0xB = Rn − imm − (NOT C), 0xD = Rn − imm, 0xE = imm − Rn, each modulo 2^32.
- R5: With destination index 15 and set-flags 1, codes 0, 4, 8 and 0xD drive the register write enable to 0 and the flag write enable to 1.
- R6: Codes 5, 6, 7, 9, 0xC and 0xF set illegal to 1. They drive both write enables, the result and the flags to 0.
- R7: For a legal code, the flag write enable equals set-flags. When it is 1, N is result bit 31 and Z is 1 exactly when the result is zero.
- R8: For arithmetic codes, C is the carry-out of the addition, which is NOT borrow for subtractions. V is the signed overflow of the operation performed.
- R9: For logical codes, C takes the carry input from the immediate expander and V keeps the current overflow input.
- R10: For every legal code except a test or compare form, the register write enable is 1 and the destination index output equals the destination index input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation code |
| set_flags | input | 1 | Update the flags when 1 |
| dst_idx | input | IDX_W | Destination register index |
| src_idx | input | IDX_W | First-source register index |
| src_val | input | DATA_W | First-source register value |
| imm_val | input | DATA_W | Expanded immediate operand |
| carry_in | input | 1 | Current carry flag |
| ovf_in | input | 1 | Current overflow flag |
| imm_carry | input | 1 | Carry-out from the immediate expander |
| res_q | output | DATA_W | Registered result |
| reg_we_q | output | 1 | Register write enable |
| reg_dst_q | output | IDX_W | Register write index |
| flag_n_q | output | 1 | Negative flag |
| flag_z_q | output | 1 | Zero flag |
| flag_c_q | output | 1 | Carry flag |
| flag_v_q | output | 1 | Overflow flag |
| flag_we_q | output | 1 | Flag write enable |
| illegal_q | output | 1 | Undefined operation code seen |

## Verification
The bench builds the unit with its defaults, DATA_W = 32 and IDX_W = 4. With these values the all-ones index is 15, so the test, compare and move aliases can be reached directly. The 32-bit width brings the signed boundaries 0x7FFFFFFF and 0x80000000, and the unsigned wrap at 0xFFFFFFFF, within reach of the overflow and carry checks. The expected value of each operation comes from 64-bit integer arithmetic in the bench, not from an adder model.

// File: rtl/imm_dp_pkg.sv
package imm_dp_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_AND = 4'h0;
    localparam logic [OPC_W-1:0] OPC_BIC = 4'h1;
    localparam logic [OPC_W-1:0] OPC_ORR = 4'h2;
    localparam logic [OPC_W-1:0] OPC_ORN = 4'h3;
    localparam logic [OPC_W-1:0] OPC_EOR = 4'h4;
    localparam logic [OPC_W-1:0] OPC_ADD = 4'h8;
    localparam logic [OPC_W-1:0] OPC_ADC = 4'hA;
    localparam logic [OPC_W-1:0] OPC_SBC = 4'hB;
    localparam logic [OPC_W-1:0] OPC_SUB = 4'hD;
    localparam logic [OPC_W-1:0] OPC_RSB = 4'hE;

    typedef enum logic [2:0] {
        LOP_AND,
        LOP_ANDN,
        LOP_OR,
        LOP_ORN,
        LOP_XOR
    } lop_e;

    typedef enum logic [1:0] {
        CIN_ZERO,
        CIN_ONE,
        CIN_FLAG
    } cin_e;

    typedef struct packed {
        logic is_arith;
        lop_e lop;
        logic swap;
        logic inv_b;
        cin_e cin;
        logic zero_a;
        logic reg_we;
        logic flag_we;
        logic illegal;
    } dec_t;

endpackage

// File: rtl/imm_dp_decode.sv
module imm_dp_decode
    import imm_dp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [OPC_W-1:0] op_code,
    input  logic             set_flags,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] src_idx,
    output dec_t             dec
);

    localparam logic [IDX_W-1:0] SPECIAL_IDX = {IDX_W{1'b1}};

    logic dst_special;
    logic src_special;
    logic flag_only;

    assign dst_special = (dst_idx == SPECIAL_IDX);
    assign src_special = (src_idx == SPECIAL_IDX);
    assign flag_only   = dst_special && set_flags;

    always_comb begin
        dec          = '0;
        dec.lop      = LOP_AND;
        dec.cin      = CIN_ZERO;
        dec.reg_we   = 1'b1;
        dec.flag_we  = set_flags;
        unique case (op_code)
            OPC_AND: begin
                dec.lop    = LOP_AND;
                dec.reg_we = !flag_only;
            end
            OPC_BIC: dec.lop = LOP_ANDN;
            OPC_ORR: begin
                dec.lop    = LOP_OR;
                dec.zero_a = src_special;
            end
            OPC_ORN: begin
                dec.lop    = LOP_ORN;
                dec.zero_a = src_special;
            end
            OPC_EOR: begin
                dec.lop    = LOP_XOR;
                dec.reg_we = !flag_only;
            end
            OPC_ADD: begin
                dec.is_arith = 1'b1;
                dec.cin      = CIN_ZERO;
                dec.reg_we   = !flag_only;
            end
            OPC_ADC: begin
                dec.is_arith = 1'b1;
                dec.cin      = CIN_FLAG;
            end
            OPC_SBC: begin
                dec.is_arith = 1'b1;
                dec.inv_b    = 1'b1;
                dec.cin      = CIN_FLAG;
            end
            OPC_SUB: begin
                dec.is_arith = 1'b1;
                dec.inv_b    = 1'b1;
                dec.cin      = CIN_ONE;
                dec.reg_we   = !flag_only;
            end
            OPC_RSB: begin
                dec.is_arith = 1'b1;
                dec.swap     = 1'b1;
                dec.inv_b    = 1'b1;
                dec.cin      = CIN_ONE;
            end
            default: begin
                dec.illegal = 1'b1;
                dec.reg_we  = 1'b0;
                dec.flag_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/imm_dp_logic.sv
module imm_dp_logic
    import imm_dp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  lop_e              lop,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        unique case (lop)
            LOP_AND:  y = opa & opb;
            LOP_ANDN: y = opa & ~opb;
            LOP_OR:   y = opa | opb;
            LOP_ORN:  y = opa | ~opb;
            LOP_XOR:  y = opa ^ opb;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/imm_dp_arith.sv
module imm_dp_arith
    import imm_dp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              swap,
    input  logic              inv_b,
    input  cin_e              cin_sel,
    input  logic              carry_flag,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] x;
    logic [DATA_W-1:0] y_raw;
    logic [DATA_W-1:0] y;
    logic              cin_bit;
    logic [DATA_W:0]   wide;

    assign x     = swap ? opb : opa;
    assign y_raw = swap ? opa : opb;
    assign y     = inv_b ? ~y_raw : y_raw;

    always_comb begin
        unique case (cin_sel)
            CIN_ZERO: cin_bit = 1'b0;
            CIN_ONE:  cin_bit = 1'b1;
            CIN_FLAG: cin_bit = carry_flag;
            default:  cin_bit = 1'b0;
        endcase
    end

    assign wide = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin_bit};
    assign sum  = wide[MSB:0];
    assign cout = wide[DATA_W];
    assign ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

endmodule

// File: rtl/imm_dp_exec.sv
module imm_dp_exec
    import imm_dp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_code,
    input  logic              set_flags,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] imm_val,
    input  logic              carry_in,
    input  logic              ovf_in,
    input  logic              imm_carry,
    output logic [DATA_W-1:0] res_q,
    output logic              reg_we_q,
    output logic [IDX_W-1:0]  reg_dst_q,
    output logic              flag_n_q,
    output logic              flag_z_q,
    output logic              flag_c_q,
    output logic              flag_v_q,
    output logic              flag_we_q,
    output logic              illegal_q
);

    localparam int MSB = DATA_W - 1;

    dec_t              dec;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] log_y;
    logic [DATA_W-1:0] ar_sum;
    logic              ar_cout;
    logic              ar_ovf;

    logic [DATA_W-1:0] res_d;
    logic              n_d, z_d, c_d, v_d;

    imm_dp_decode #(.IDX_W(IDX_W)) u_dec (
        .op_code   (op_code),
        .set_flags (set_flags),
        .dst_idx   (dst_idx),
        .src_idx   (src_idx),
        .dec       (dec)
    );

    assign opa = dec.zero_a ? '0 : src_val;

    imm_dp_logic #(.DATA_W(DATA_W)) u_log (
        .lop (dec.lop),
        .opa (opa),
        .opb (imm_val),
        .y   (log_y)
    );

    imm_dp_arith #(.DATA_W(DATA_W)) u_ar (
        .opa        (opa),
        .opb        (imm_val),
        .swap       (dec.swap),
        .inv_b      (dec.inv_b),
        .cin_sel    (dec.cin),
        .carry_flag (carry_in),
        .sum        (ar_sum),
        .cout       (ar_cout),
        .ovf        (ar_ovf)
    );

    always_comb begin
        if (dec.illegal) begin
            res_d = '0;
            n_d   = 1'b0;
            z_d   = 1'b0;
            c_d   = 1'b0;
            v_d   = 1'b0;
        end else begin
            res_d = dec.is_arith ? ar_sum : log_y;
            n_d   = res_d[MSB];
            z_d   = (res_d == '0);
            c_d   = dec.is_arith ? ar_cout : imm_carry;
            v_d   = dec.is_arith ? ar_ovf  : ovf_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            reg_we_q  <= 1'b0;
            reg_dst_q <= '0;
            flag_n_q  <= 1'b0;
            flag_z_q  <= 1'b0;
            flag_c_q  <= 1'b0;
            flag_v_q  <= 1'b0;
            flag_we_q <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            res_q     <= res_d;
            reg_we_q  <= dec.reg_we;
            reg_dst_q <= dec.illegal ? '0 : dst_idx;
            flag_n_q  <= n_d;
            flag_z_q  <= z_d;
            flag_c_q  <= c_d;
            flag_v_q  <= v_d;
            flag_we_q <= dec.flag_we;
            illegal_q <= dec.illegal;
        end
    end

endmodule

// File: rtl/imm_dp_exec_chk.sv
module imm_dp_exec_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op_code,
    input logic              set_flags,
    input logic [IDX_W-1:0]  dst_idx,
    input logic [IDX_W-1:0]  src_idx,
    input logic [DATA_W-1:0] imm_val,
    input logic              ovf_in,
    input logic              imm_carry,
    input logic [DATA_W-1:0] res_q,
    input logic              reg_we_q,
    input logic              flag_n_q,
    input logic              flag_z_q,
    input logic              flag_c_q,
    input logic              flag_v_q,
    input logic              flag_we_q,
    input logic              illegal_q
);

    localparam logic [IDX_W-1:0] SPECIAL_IDX = {IDX_W{1'b1}};

    logic is_bad;
    logic is_logic;
    logic is_cmp_form;

    assign is_bad = (op_code == 4'h5) || (op_code == 4'h6) || (op_code == 4'h7) ||
                    (op_code == 4'h9) || (op_code == 4'hC) || (op_code == 4'hF);
    assign is_logic = (op_code <= 4'h4);
    assign is_cmp_form = set_flags && (dst_idx == SPECIAL_IDX) &&
                         ((op_code == 4'h0) || (op_code == 4'h4) ||
                          (op_code == 4'h8) || (op_code == 4'hD));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (res_q == '0 && !reg_we_q && !flag_we_q && !illegal_q &&
                 !flag_n_q && !flag_z_q && !flag_c_q && !flag_v_q));

    // R3
    move_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'h2 && src_idx == SPECIAL_IDX) |=> (res_q == $past(imm_val)));

    // R5
    compare_form_chk: assert property (@(posedge clk) disable iff (rst)
        is_cmp_form |=> (!reg_we_q && flag_we_q));

    // R6
    illegal_raise_chk: assert property (@(posedge clk) disable iff (rst)
        is_bad |=> illegal_q);

    // R6
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_q |-> (!reg_we_q && !flag_we_q));

    // R7
    nz_flags_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we_q |-> (flag_n_q == res_q[DATA_W-1] && flag_z_q == (res_q == '0)));

    // R9
    logic_cv_chk: assert property (@(posedge clk) disable iff (rst)
        (is_logic && set_flags) |=> (flag_c_q == $past(imm_carry) && flag_v_q == $past(ovf_in)));

endmodule

bind imm_dp_exec imm_dp_exec_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_code   (op_code),
    .set_flags (set_flags),
    .dst_idx   (dst_idx),
    .src_idx   (src_idx),
    .imm_val   (imm_val),
    .ovf_in    (ovf_in),
    .imm_carry (imm_carry),
    .res_q     (res_q),
    .reg_we_q  (reg_we_q),
    .flag_n_q  (flag_n_q),
    .flag_z_q  (flag_z_q),
    .flag_c_q  (flag_c_q),
    .flag_v_q  (flag_v_q),
    .flag_we_q (flag_we_q),
    .illegal_q (illegal_q)
);

// File: tb/tb_imm_dp_exec.sv
module tb_imm_dp_exec;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic [3:0]        op_code;
    logic              set_flags;
    logic [IDX_W-1:0]  dst_idx;
    logic [IDX_W-1:0]  src_idx;
    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] imm_val;
    logic              carry_in;
    logic              ovf_in;
    logic              imm_carry;
    logic [DATA_W-1:0] res_q;
    logic              reg_we_q;
    logic [IDX_W-1:0]  reg_dst_q;
    logic              flag_n_q, flag_z_q, flag_c_q, flag_v_q;
    logic              flag_we_q;
    logic              illegal_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    imm_dp_exec #(.DATA_W(DATA_W), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst(rst), .op_code(op_code), .set_flags(set_flags),
        .dst_idx(dst_idx), .src_idx(src_idx), .src_val(src_val), .imm_val(imm_val),
        .carry_in(carry_in), .ovf_in(ovf_in), .imm_carry(imm_carry),
        .res_q(res_q), .reg_we_q(reg_we_q), .reg_dst_q(reg_dst_q),
        .flag_n_q(flag_n_q), .flag_z_q(flag_z_q), .flag_c_q(flag_c_q),
        .flag_v_q(flag_v_q), .flag_we_q(flag_we_q), .illegal_q(illegal_q)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic ovf_of(input longint v);
        return (v > 64'sd2147483647) || (v < -64'sd2147483648);
    endfunction

    task automatic run_op(input string tag, input logic [3:0] op, input logic s,
                          input logic [3:0] dst, input logic [3:0] src,
                          input logic [31:0] rn, input logic [31:0] imm,
                          input logic cin, input logic vin, input logic shc);
        logic [31:0] r;
        logic c, v, bad, arith, test, rwe, fwe;
        logic [31:0] a;
        longint sa, sb, ua, ub;
        logic cb;
        bad   = (op == 4'h5) || (op == 4'h6) || (op == 4'h7) ||
                (op == 4'h9) || (op == 4'hC) || (op == 4'hF);
        arith = (op >= 4'h8);
        test  = s && (dst == 4'hF) &&
                (op == 4'h0 || op == 4'h4 || op == 4'h8 || op == 4'hD);
        a  = ((op == 4'h2 || op == 4'h3) && src == 4'hF) ? 32'h0 : rn;
        sa = longint'($signed(rn));
        sb = longint'($signed(imm));
        ua = longint'({32'h0, rn});
        ub = longint'({32'h0, imm});
        cb = ~cin;
        c  = shc;
        v  = vin;
        r  = '0;
        case (op)
            4'h0: r = a & imm;
            4'h1: r = a & ~imm;
            4'h2: r = a | imm;
            4'h3: r = a | ~imm;
            4'h4: r = a ^ imm;
            4'h8: begin r = rn + imm; c = (ua + ub) > 64'hFFFFFFFF; v = ovf_of(sa + sb); end
            4'hA: begin r = rn + imm + {31'h0, cin}; c = (ua + ub + longint'(cin)) > 64'hFFFFFFFF;
                        v = ovf_of(sa + sb + longint'(cin)); end
            4'hB: begin r = rn - imm - {31'h0, cb}; c = ua >= (ub + longint'(cb));
                        v = ovf_of(sa - sb - longint'(cb)); end
            4'hD: begin r = rn - imm; c = ua >= ub; v = ovf_of(sa - sb); end
            4'hE: begin r = imm - rn; c = ub >= ua; v = ovf_of(sb - sa); end
            default: r = '0;
        endcase
        rwe = !bad && !test;
        fwe = !bad && s;
        if (!arith || bad) begin
            if (!bad) begin c = shc; v = vin; end
        end

        @(negedge clk);
        op_code = op; set_flags = s; dst_idx = dst; src_idx = src;
        src_val = rn; imm_val = imm; carry_in = cin; ovf_in = vin; imm_carry = shc;
        @(posedge clk);
        @(negedge clk);
        check(tag, "result", 64'(res_q), 64'(r));
        check(tag, "reg_we", 64'(reg_we_q), 64'(rwe));
        check(tag, "flag_we", 64'(flag_we_q), 64'(fwe));
        check(tag, "illegal", 64'(illegal_q), 64'(bad));
        if (rwe) check(tag, "reg_dst", 64'(reg_dst_q), 64'(dst));
        if (fwe) begin
            check(tag, "N", 64'(flag_n_q), 64'(r[31]));
            check(tag, "Z", 64'(flag_z_q), 64'(r == 32'h0));
            check(tag, "C", 64'(flag_c_q), 64'(c));
            check(tag, "V", 64'(flag_v_q), 64'(v));
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        op_code = 4'h8; set_flags = 1'b1; dst_idx = 4'h3; src_idx = 4'h1;
        src_val = 32'hFFFF_FFFF; imm_val = 32'h1; carry_in = 1'b1; ovf_in = 1'b1; imm_carry = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "result", 64'(res_q), 64'h0);
        check("R1", "reg_we", 64'(reg_we_q), 64'h0);
        check("R1", "reg_dst", 64'(reg_dst_q), 64'h0);
        check("R1", "flags", 64'({flag_n_q, flag_z_q, flag_c_q, flag_v_q}), 64'h0);
        check("R1", "flag_we", 64'(flag_we_q), 64'h0);
        check("R1", "illegal", 64'(illegal_q), 64'h0);
        rst = 1'b0;
    endtask

    task automatic t_logic;
        run_op("R2", 4'h0, 1'b0, 4'h2, 4'h1, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, 0);
        run_op("R2", 4'h1, 1'b0, 4'h5, 4'h6, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, 0);
        run_op("R2", 4'h2, 1'b0, 4'h7, 4'h3, 32'h8000_0001, 32'h0000_FF00, 0, 0, 0);
        run_op("R2", 4'h3, 1'b0, 4'h0, 4'h3, 32'h0000_0001, 32'hFFFF_0000, 0, 0, 0);
        run_op("R2", 4'h4, 1'b0, 4'hE, 4'h4, 32'hAAAA_5555, 32'hFFFF_FFFF, 0, 0, 0);
    endtask

    task automatic t_moves;
        run_op("R3", 4'h2, 1'b0, 4'h4, 4'hF, 32'hDEAD_BEEF, 32'h0000_00FF, 0, 0, 0);
        run_op("R3", 4'h3, 1'b1, 4'h4, 4'hF, 32'hDEAD_BEEF, 32'h0000_00FF, 0, 1, 1);
    endtask

    task automatic t_arith;
        run_op("R4", 4'h8, 1'b1, 4'h1, 4'h2, 32'h0000_1000, 32'h0000_0234, 0, 0, 0);
        run_op("R8", 4'h8, 1'b1, 4'h1, 4'h2, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 0);
        run_op("R8", 4'h8, 1'b1, 4'h1, 4'h2, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0);
        run_op("R4", 4'hA, 1'b1, 4'h1, 4'h2, 32'h0000_0010, 32'h0000_0005, 1, 0, 0);
        run_op("R4", 4'hA, 1'b1, 4'h1, 4'h2, 32'h0000_0010, 32'h0000_0005, 0, 0, 0);
        run_op("R4", 4'hB, 1'b1, 4'h1, 4'h2, 32'h0000_0010, 32'h0000_0005, 0, 0, 0);
        run_op("R4", 4'hB, 1'b1, 4'h1, 4'h2, 32'h0000_0005, 32'h0000_0005, 1, 0, 0);
        run_op("R8", 4'hD, 1'b1, 4'h1, 4'h2, 32'h8000_0000, 32'h0000_0001, 0, 0, 0);
        run_op("R8", 4'hD, 1'b1, 4'h1, 4'h2, 32'h0000_0003, 32'h0000_0005, 0, 0, 0);
        run_op("R4", 4'hE, 1'b1, 4'h1, 4'h2, 32'h0000_0003, 32'h0000_0005, 0, 0, 0);
        run_op("R4", 4'hE, 1'b0, 4'h9, 4'h2, 32'h0000_0007, 32'h0000_0005, 0, 0, 0);
    endtask

    task automatic t_compare;
        run_op("R5", 4'h0, 1'b1, 4'hF, 4'h1, 32'h0000_00F0, 32'h0000_000F, 0, 1, 1);
        run_op("R5", 4'h4, 1'b1, 4'hF, 4'h1, 32'h1234_5678, 32'h1234_5678, 0, 0, 0);
        run_op("R5", 4'h8, 1'b1, 4'hF, 4'h1, 32'h8000_0000, 32'h8000_0000, 0, 0, 0);
        run_op("R5", 4'hD, 1'b1, 4'hF, 4'h1, 32'h0000_0009, 32'h0000_0009, 0, 0, 0);
        run_op("R10", 4'hD, 1'b0, 4'hF, 4'h1, 32'h0000_0009, 32'h0000_0002, 0, 0, 0);
    endtask

    task automatic t_illegal;
        logic [3:0] bad_codes [6] = '{4'h5, 4'h6, 4'h7, 4'h9, 4'hC, 4'hF};
        for (int i = 0; i < 6; i++)
            run_op("R6", bad_codes[i], 1'b1, 4'h3, 4'h2, 32'hFFFF_FFFF, 32'h1, 1, 1, 1);
    endtask

    task automatic t_flags;
        run_op("R7", 4'h1, 1'b0, 4'h6, 4'h2, 32'hFFFF_FFFF, 32'h0, 0, 0, 1);
        run_op("R7", 4'h0, 1'b1, 4'h6, 4'h2, 32'hFFFF_0000, 32'h0000_FFFF, 1, 0, 0);
        run_op("R9", 4'h4, 1'b1, 4'h6, 4'h2, 32'h8000_0000, 32'h0000_0001, 0, 1, 1);
        run_op("R10", 4'h2, 1'b1, 4'hB, 4'h2, 32'h1, 32'h2, 0, 0, 0);
    endtask

    initial begin
        rst = 1'b1;
        op_code = '0; set_flags = 0; dst_idx = '0; src_idx = '0;
        src_val = '0; imm_val = '0; carry_in = 0; ovf_in = 0; imm_carry = 0;
        repeat (2) @(posedge clk);
        t_reset();
        t_logic();
        t_moves();
        t_arith();
        t_compare();
        t_illegal();
        t_flags();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule